// File: doc/BRIEF.md
# Pulse Accumulator with Gated Time Mode

This block is an 8-bit accumulator that a processor programs over a simple byte-wide register bus. It has two modes. In event mode it adds one for each chosen edge on an external pin. In gated mode it adds one per 64 system clocks, and the pin level holds the count back while it sits at a chosen inhibit level. Software can load the counter with any value. This lets it set up an overflow after a known number of events: a load of 246 followed by ten events wraps the counter.

The block has two sticky flags: counter wrap and selected pin edge. Software clears each flag by writing a one to its bit. Each flag has a mask bit of its own, and a set flag whose mask bit is set drives the interrupt output. The pin passes through a two-stage synchronizer before it is used. The divide-by-64 tick comes from a free-running prescaler that takes no notice of loads or of the enable bit.

Register map (address on `addr`): 0 = control (bit 0 run, bit 1 gated mode, bit 2 polarity), 1 = counter, 2 = flags, 3 = masks. In the flag and mask registers, bit 5 is overflow and bit 4 is edge. Bits that are not implemented read as 0.

Top module: `pulse_accum`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: While control bit 0 (run) is 0, the counter keeps its value and neither flag sets, whatever the pin or the tick does.
- R3: In event mode (control bit 1 = 0), polarity 0 (control bit 2) counts falling pin edges and polarity 1 counts rising pin edges, one increment per edge. The counter reflects an edge no later than 4 clocks after the pin changes.
- R4: In gated mode (control bit 1 = 1), the counter gains exactly K over any window of 64*K clocks while the pin is held at the level that permits counting. With polarity 0, a low pin stops counting. With polarity 1, a high pin stops counting.
- R5: Flag bit 5 sets when the counter wraps from 0xFF to 0x00, in either mode.
- R6: Flag bit 4 sets on a pin edge of the kind that polarity selects (1 = rising, 0 = falling) while run is 1.
- R7: A write to address 1 loads the counter. After a load of 246, the tenth counted event leaves the counter at 0x00 with bit 5 set, and the ninth event leaves it at 0xFF with bit 5 clear.
- R8: Writing a 1 to flag bit 5 or bit 4 clears that flag. Writing a 0 leaves it unchanged.
- R9: `irq` is high exactly when (flag 5 and mask 5) or (flag 4 and mask 4).
- R10: A counter write in the same cycle as an increment wins. The written value is stored, and no wrap is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| pin | input | 1 | External event / gate input |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps run, polarity and pulse count in event mode. It starts from a value near the top so that runs with and without a wrap both occur. A design that picked the wrong edge, or counted while disabled, would end on a different count or a stray edge flag. In gated mode, all four pin/polarity pairs are measured over an exact multiple of 64 clocks. A swapped inhibit level shows up as growth of zero where three was expected. The 246-load boundary is checked at the ninth and tenth event, which would catch a wrap flag raised one event early. Continuous counter writes during gated counting catch an increment that beats the load, because it would leave 0x00 and set the overflow flag.

// File: rtl/pa_pkg.sv
// Package: shared register addresses, bit positions and the control record
// for the pulse accumulator. Assumes an 8-bit register bus.
package pa_pkg;
    localparam int BUS_W = 8;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_FLAG = 2'd2;
    localparam logic [1:0] A_MASK = 2'd3;
    localparam int B_OVF  = 5;
    localparam int B_EDGE = 4;

    typedef struct packed {
        logic pol;
        logic gated;
        logic run;
    } pa_ctrl_t;
endpackage

// File: rtl/pa_pin_sync.sv
// Module: brings the asynchronous pin into the clock domain through STAGES
// flops and flags rising and falling transitions of the synchronized level.
// Assumes pin pulses last longer than one clock.
module pa_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Decode level and transitions.
    always_comb begin
        lvl  = sync_q[STAGES-1];
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
    end
endmodule

// File: rtl/pa_prescaler.sv
// Module: free-running divider that pulses tick for one clock every DIV
// clocks. Assumes DIV >= 2. It is not affected by the accumulator's loads
// or enable.
module pa_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    // Tick on the final phase of each period.
    always_comb tick = (div_q == LAST);
endmodule

// File: rtl/pa_counter.sv
// Module: loadable up-counter. A load takes priority over an increment in
// the same cycle. wrap pulses when an increment carries out of the top.
module pa_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    logic [CW-1:0] cnt_q;

    // Update the count: load first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (inc)  cnt_q <= cnt_q + 1'b1;
    end

    // Carry-out of an increment that actually takes effect.
    always_comb begin
        cnt  = cnt_q;
        wrap = inc && !load && (cnt_q == {CW{1'b1}});
    end
endmodule

// File: rtl/pulse_accum.sv
// Module: pulse accumulator top. It holds the control, flag and mask
// registers, selects the counting source (pin edge, or gated prescaler
// tick) and forms the interrupt. Assumes CW <= 8 so the counter fits one
// bus byte. All registers use a synchronous active-low reset.
module pulse_accum
    import pa_pkg::*;
#(
    parameter int CW     = 8,
    parameter int DIV    = 64,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             pin,
    output logic             irq
);
    pa_ctrl_t      ctrl_q;
    logic          ovf_q, edg_q, mk_ovf_q, mk_edg_q;
    logic          lvl, rise, fall, tick, sel_edge, inc, load, wrap;
    logic [CW-1:0] cnt_q;
    logic          wr_ctrl, wr_flag, wr_mask;

    pa_pin_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    pa_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pa_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(wdata[CW-1:0]),
        .inc(inc), .cnt(cnt_q), .wrap(wrap)
    );

    // Decode register writes and select the counting event.
    always_comb begin
        wr_ctrl  = wr_en && (addr == A_CTRL);
        load     = wr_en && (addr == A_CNT);
        wr_flag  = wr_en && (addr == A_FLAG);
        wr_mask  = wr_en && (addr == A_MASK);
        sel_edge = ctrl_q.pol ? rise : fall;
        if (!ctrl_q.run)     inc = 1'b0;
        else if (ctrl_q.gated) inc = tick && (lvl ^ ctrl_q.pol);
        else                   inc = sel_edge;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= pa_ctrl_t'(wdata[2:0]);
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mk_ovf_q <= 1'b0;
            mk_edg_q <= 1'b0;
        end else if (wr_mask) begin
            mk_ovf_q <= wdata[B_OVF];
            mk_edg_q <= wdata[B_EDGE];
        end
    end

    // Sticky flags: hardware set, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            edg_q <= 1'b0;
        end else begin
            ovf_q <= wrap | (ovf_q & ~(wr_flag & wdata[B_OVF]));
            edg_q <= (ctrl_q.run & sel_edge) | (edg_q & ~(wr_flag & wdata[B_EDGE]));
        end
    end

    // Read mux and interrupt output.
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: rdata[2:0] = ctrl_q;
            A_CNT:  rdata[CW-1:0] = cnt_q;
            A_FLAG: begin rdata[B_OVF] = ovf_q; rdata[B_EDGE] = edg_q; end
            default: begin rdata[B_OVF] = mk_ovf_q; rdata[B_EDGE] = mk_edg_q; end
        endcase
        irq = (ovf_q & mk_ovf_q) | (edg_q & mk_edg_q);
    end
endmodule

// File: rtl/pulse_accum_chk.sv
// Checker: temporal properties of the pulse accumulator, bound to the top.
module pulse_accum_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    addr,
    input logic [7:0]    wdata,
    input logic          irq,
    input logic [CW-1:0] cnt,
    input logic          run,
    input logic          ovf,
    input logic          edg,
    input logic          inc
);
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && addr == 2'd1)) |=> $stable(cnt)); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> (cnt == $past(wdata[CW-1:0]))); // R10
    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !(wr_en && addr == 2'd1) && cnt == {CW{1'b1}}) |=> ovf); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd1) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R3
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf || edg)); // R9
endmodule

bind pulse_accum pulse_accum_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .cnt(cnt_q), .run(ctrl_q.run), .ovf(ovf_q), .edg(edg_q),
    .inc(inc)
);

// File: tb/tb_pulse_accum.sv
// Bench: sweeps modes, polarities and pulse counts; expected values are
// computed arithmetically from the requirements.
module tb_pulse_accum;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       pin = 1'b0;
    logic       irq;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pulse_accum dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin(pin), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pin = 1'b1;
            repeat (3) @(negedge clk);
            pin = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v, c0, c1;
        int cnts[4] = '{0, 1, 5, 10};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reset reg", v, 8'h00);
        end
        chk("R1 reset irq", {7'd0, irq}, 8'h00);

        // R2 R3 R5 R6: event-mode sweep over run, polarity, pulse count
        for (int pol = 0; pol < 2; pol++)
            for (int en = 0; en < 2; en++)
                for (int k = 0; k < 4; k++) begin
                    int n = cnts[k];
                    int s = 8'hF8;
                    wr(2'd0, {5'd0, pol[0], 1'b0, en[0]});
                    wr(2'd1, s[7:0]);
                    wr(2'd2, 8'h30);
                    pulses(n);
                    rd(2'd1, v);
                    chk(en ? "R3 event count" : "R2 hold when off", v,
                        en ? 8'((s + n) & 255) : s[7:0]);
                    rd(2'd2, v);
                    chk("R5 R6 flags after pulses", v,
                        {2'b00, (en == 1 && s + n > 255), (en == 1 && n > 0), 4'h0});
                end

        // R7: load 246, ninth and tenth rising edges
        wr(2'd0, 8'h05);
        wr(2'd1, 8'd246);
        wr(2'd2, 8'h30);
        pulses(9);
        rd(2'd1, v); chk("R7 ninth event count", v, 8'hFF);
        rd(2'd2, v); chk("R7 ninth event no ovf", v & 8'h20, 8'h00);
        pulses(1);
        rd(2'd1, v); chk("R7 tenth event count", v, 8'h00);
        rd(2'd2, v); chk("R7 tenth event ovf", v & 8'h20, 8'h20);

        // R9: interrupt masking (ovf and edge flags both set now)
        wr(2'd3, 8'h00); rd(2'd3, v); chk("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h20); rd(2'd3, v); chk("R9 irq ovf mask", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h20); rd(2'd2, v); chk("R9 irq after ovf clear", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h10); rd(2'd3, v); chk("R9 irq edge mask", {7'd0, irq}, 8'h01);

        // R8: write-one-to-clear, zero has no effect
        wr(2'd2, 8'h00); rd(2'd2, v); chk("R8 zero write keeps edge", v, 8'h10);
        wr(2'd2, 8'h10); rd(2'd2, v); chk("R8 one write clears edge", v, 8'h00);
        wr(2'd3, 8'h00);

        // R4 R2: gated mode over an exact 3*64 clock window
        for (int en = 0; en < 2; en++)
            for (int pol = 0; pol < 2; pol++)
                for (int lv = 0; lv < 2; lv++) begin
                    wr(2'd0, {5'd0, pol[0], 1'b1, en[0]});
                    @(negedge clk); pin = lv[0];
                    repeat (8) @(negedge clk);
                    addr = 2'd1;
                    #1 c0 = rdata;
                    repeat (192) @(negedge clk);
                    #1 c1 = rdata;
                    chk(en ? "R4 gated growth" : "R2 gated hold", c1 - c0,
                        (en == 1 && lv != pol) ? 8'd3 : 8'd0);
                end

        // R5: overflow in gated mode
        wr(2'd0, 8'h03);
        @(negedge clk); pin = 1'b1;
        wr(2'd2, 8'h30);
        wr(2'd1, 8'hFF);
        repeat (70) @(negedge clk);
        rd(2'd2, v); chk("R5 gated wrap ovf", v & 8'h20, 8'h20);

        // R10: counter writes every cycle while gated ticks arrive
        wr(2'd2, 8'h30);
        @(negedge clk);
        addr = 2'd1; wdata = 8'hFF; wr_en = 1'b1;
        repeat (200) @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R10 load wins count", rdata, 8'hFF);
        rd(2'd2, v); chk("R10 no ovf from overridden step", v & 8'h20, 8'h00);

        finish_run();
    end
endmodule